// File: doc/BRIEF.md
# MIDI Host Port (UART Mode)

This block sits on a host I/O bus and presents a simple byte-serial MIDI port, modelled on a legacy MIDI adapter running in its plain pass-through UART mode. It answers two consecutive byte addresses inside a 10-bit I/O space. The even address is the data port and the odd address is the command port on write and the status port on read. The base is an input and must be a multiple of 8. Any set address bit above bit 9 stops the block from responding, so there are no alias addresses.

Bytes written to the data port go through a transmit queue to a serial transmitter at MIDI rate. Bytes from the serial receiver go into a receive queue. Every command write also pushes an acknowledge byte into that same receive queue, and the status port reports its low six bits back. An interrupt line is raised when a byte enters the receive queue and is cleared when the host reads the data port. Sticky overrun flags record any byte lost to a full queue.

Top module: `midi_host_port`

## Requirements
- R1: The block responds only when addr[15:10] is zero, addr[9:3] equals base_addr[9:3] and addr[2:1] is zero. addr[0]=0 selects the data port and addr[0]=1 selects the command/status port. All other accesses have no effect.
- R2: Each byte accepted at the data port is sent on txd as a start bit (0), eight data bits LSB first and a stop bit (1). Each bit lasts DIV clocks. txd idles high, and bytes leave in the order they were written.
- R3: The transmit queue holds DEPTH (16) bytes. Status bit 6 reads 1 while it is full. A data write to a full queue is dropped and sets tx_ovr, which stays set until reset.
- R4: A frame on rxd is sampled at mid-bit. A frame with a high stop bit puts its byte into the receive queue. A frame with a low stop bit is dropped.
- R5: The receive queue holds DEPTH (16) bytes. Status bit 7 reads 1 when it is empty and 0 when data is waiting. A byte arriving while it is full is dropped and sets rx_ovr, which stays set until reset.
- R6: A command write stores the low six bits of the written byte, and status bits 5..0 return them. The same write pushes the acknowledge byte 0xFE into the receive queue, and the status port shows it from the next cycle.
- R7: When an acknowledge and a received serial byte arrive in the same cycle, the acknowledge is queued first and the serial byte in a following cycle. Neither byte is lost.
- R8: irq rises in the cycle after a byte is accepted into the receive queue. A data-port read clears it unless a byte is accepted in that same cycle.
- R9: A data-port read from an empty receive queue returns the last byte read and leaves the queue unchanged.
- R10: After reset, irq=0, txd=1, tx_ovr=0, rx_ovr=0, status reads 0x80 and a data-port read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 10 | I/O base; bits 2..0 ignored |
| addr | input | 16 | Host I/O address |
| wr_en | input | 1 | Host write strobe, one cycle per access |
| rd_en | input | 1 | Host read strobe, one cycle per access |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the addressed port |
| irq | output | 1 | Receive-data interrupt |
| txd | output | 1 | MIDI serial output |
| rxd | input | 1 | MIDI serial input |
| tx_ovr | output | 1 | Sticky transmit overrun |
| rx_ovr | output | 1 | Sticky receive overrun |

## Verification
The transmit path is tested with bytes written one at a time and with a burst long enough to fill the queue. The burst separates correct ordering and capacity from losses at the boundary. The receive path is tested with well-formed frames, a frame with a bad stop bit and a 17-frame overflow run. Together these separate mid-bit sampling, stop-bit checking and full-queue dropping. A command write is swept across a window of cycle offsets around the end of an incoming frame, so the exact collision cycle is hit: no offset may lose either the acknowledge or the serial byte. Address patterns with a high bit set, with the wrong sub-slot and at a moved base check that only the two real addresses respond.

// File: rtl/midi_pkg.sv
package midi_pkg;
   localparam logic [7:0] ACK_BYTE   = 8'hFE;
   localparam int         FRAME_BITS = 10;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/midi_fifo.sv
module midi_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << PW));
   localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("midi_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("midi_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/midi_uart_tx.sv
module midi_uart_tx #(
   parameter int DIV = 4000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       q_empty,
   input  logic [7:0] q_data,
   output logic       q_pop,
   output logic       txd
);
   import midi_pkg::*;
   localparam int DW = $clog2(DIV);
   localparam logic [DW-1:0] BAUD_LAST = DW'(DIV - 1);
   localparam logic [3:0]    BIT_LAST  = 4'(FRAME_BITS - 1);

   if (DIV < 4) begin : g_bad_div
      $error("midi_uart_tx: DIV must be at least 4");
   end

   logic [FRAME_BITS-1:0] shreg;
   logic [3:0]            bit_idx;
   logic [DW-1:0]         baud;
   logic                  busy;

   assign q_pop = !busy && !q_empty;
   assign txd   = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg   <= '1;
         bit_idx <= '0;
         baud    <= '0;
         busy    <= 1'b0;
      end else if (q_pop) begin
         shreg   <= {1'b1, q_data, 1'b0};
         bit_idx <= '0;
         baud    <= '0;
         busy    <= 1'b1;
      end else if (busy) begin
         if (baud == BAUD_LAST) begin
            baud  <= '0;
            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            if (bit_idx == BIT_LAST) busy <= 1'b0;
            else bit_idx <= bit_idx + 1'b1;
         end else begin
            baud <= baud + 1'b1;
         end
      end
   end
endmodule

// File: rtl/midi_uart_rx.sv
module midi_uart_rx #(
   parameter int DIV = 4000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   output logic       valid,
   output logic [7:0] data
);
   import midi_pkg::*;
   localparam int DW = $clog2(DIV);
   localparam logic [DW-1:0] BAUD_LAST = DW'(DIV - 1);
   localparam logic [DW-1:0] HALF_LAST = DW'(DIV / 2 - 1);

   if (DIV < 4) begin : g_bad_div
      $error("midi_uart_rx: DIV must be at least 4");
   end

   logic [2:0]    sync;
   logic          line, fall;
   rx_state_e     state;
   logic [DW-1:0] baud;
   logic [2:0]    bit_idx;

   assign line = sync[1];
   assign fall = sync[2] && !sync[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync    <= '1;
         state   <= RX_IDLE;
         baud    <= '0;
         bit_idx <= '0;
         data    <= '0;
         valid   <= 1'b0;
      end else begin
         sync  <= {sync[1:0], rxd};
         valid <= 1'b0;
         case (state)
            RX_IDLE: begin
               baud <= '0;
               if (fall) state <= RX_START;
            end
            RX_START: begin
               if (baud == HALF_LAST) begin
                  baud    <= '0;
                  bit_idx <= '0;
                  state   <= line ? RX_IDLE : RX_DATA;
               end else baud <= baud + 1'b1;
            end
            RX_DATA: begin
               if (baud == BAUD_LAST) begin
                  baud <= '0;
                  data <= {line, data[7:1]};
                  if (bit_idx == 3'd7) state <= RX_STOP;
                  else bit_idx <= bit_idx + 1'b1;
               end else baud <= baud + 1'b1;
            end
            RX_STOP: begin
               if (baud == BAUD_LAST) begin
                  baud  <= '0;
                  valid <= line;
                  state <= RX_IDLE;
               end else baud <= baud + 1'b1;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port #(
   parameter int ADDR_W = 16,
   parameter int DEC_W  = 10,
   parameter int DEPTH  = 16,
   parameter int DIV    = 4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEC_W-1:0]  base_addr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq,
   output logic              txd,
   input  logic              rxd,
   output logic              tx_ovr,
   output logic              rx_ovr
);
   import midi_pkg::*;

   if (ADDR_W < DEC_W) begin : g_bad_addr
      $error("midi_host_port: ADDR_W must cover DEC_W");
   end
   if (DEC_W < 4) begin : g_bad_dec
      $error("midi_host_port: DEC_W too small for 8-aligned base");
   end

   logic upper_zero;
   if (ADDR_W > DEC_W) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:DEC_W] == '0);
   end else begin : g_no_upper
      assign upper_zero = 1'b1;
   end

   logic hit, dat_wr, cmd_wr, dat_rd;
   assign hit = upper_zero && (addr[DEC_W-1:3] == base_addr[DEC_W-1:3])
                && (addr[2:1] == 2'b00);
   assign dat_wr = wr_en && hit && !addr[0];
   assign cmd_wr = wr_en && hit &&  addr[0];
   assign dat_rd = rd_en && hit && !addr[0];

   // transmit path
   logic       tx_push, tx_pop, tx_empty, tx_full;
   logic [7:0] tx_dout;
   assign tx_push = dat_wr;

   midi_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wdata),
      .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

   midi_uart_tx #(.DIV(DIV)) u_tx (
      .clk(clk), .rst_n(rst_n), .q_empty(tx_empty), .q_data(tx_dout),
      .q_pop(tx_pop), .txd(txd));

   // receive path
   logic       rx_valid;
   logic [7:0] rx_byte;

   midi_uart_rx #(.DIV(DIV)) u_rx (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .valid(rx_valid), .data(rx_byte));

   logic       held_v;
   logic [7:0] held_b;
   logic       rx_push, rx_pop, rx_empty, rx_full;
   logic [7:0] rx_din, rx_dout;

   always_comb begin
      rx_push = 1'b0;
      rx_din  = rx_byte;
      if (cmd_wr) begin
         rx_push = 1'b1;
         rx_din  = ACK_BYTE;
      end else if (held_v) begin
         rx_push = 1'b1;
         rx_din  = held_b;
      end else if (rx_valid) begin
         rx_push = 1'b1;
      end
   end

   assign rx_pop = dat_rd && !rx_empty;

   midi_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din),
      .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

   logic [5:0] cmd_low;
   logic [7:0] last_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_v  <= 1'b0;
         held_b  <= '0;
         cmd_low <= '0;
         last_rd <= '0;
         irq     <= 1'b0;
         tx_ovr  <= 1'b0;
         rx_ovr  <= 1'b0;
      end else begin
         if (cmd_wr && rx_valid) begin
            held_v <= 1'b1;
            held_b <= rx_byte;
         end else if (!cmd_wr) begin
            held_v <= 1'b0;
         end
         if (cmd_wr) cmd_low <= wdata[5:0];
         if (rx_pop) last_rd <= rx_dout;
         if (rx_push && !rx_full) irq <= 1'b1;
         else if (dat_rd) irq <= 1'b0;
         if (tx_push && tx_full) tx_ovr <= 1'b1;
         if (rx_push && rx_full) rx_ovr <= 1'b1;
      end
   end

   always_comb begin
      if (!hit) rdata = '0;
      else if (addr[0]) rdata = {rx_empty, tx_full, cmd_low};
      else rdata = rx_empty ? last_rd : rx_dout;
   end
endmodule

// File: rtl/midi_host_port_chk.sv
module midi_host_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr,
   input logic       dat_rd,
   input logic       rx_valid,
   input logic [7:0] rx_byte,
   input logic       rx_push,
   input logic [7:0] rx_din,
   input logic       rx_full,
   input logic       rx_empty,
   input logic       tx_push,
   input logic       tx_full,
   input logic       irq,
   input logic [7:0] last_rd,
   input logic       tx_ovr,
   input logic       rx_ovr
);
   // R7
   collide_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && rx_valid |=> rx_push && (cmd_wr || rx_din == $past(rx_byte)));

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(rx_push));

   // R8
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_rd && !rx_push |=> !irq);

   // R9
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_rd && rx_empty |=> $stable(last_rd));

   // R3
   tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push && tx_full |=> tx_ovr);

   // R5
   rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && rx_full |=> rx_ovr);

   // R5
   rx_ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rx_ovr) |-> rx_ovr);
endmodule

bind midi_host_port midi_host_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_rd(dat_rd),
   .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_push(rx_push),
   .rx_din(rx_din), .rx_full(rx_full), .rx_empty(rx_empty),
   .tx_push(tx_push), .tx_full(tx_full), .irq(irq), .last_rd(last_rd),
   .tx_ovr(tx_ovr), .rx_ovr(rx_ovr));

// File: tb/tb_midi_host_port.sv
module tb_midi_host_port;
   localparam int DIV = 16;
   localparam logic [15:0] BASE = 16'h0330;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  base_addr = 10'h330;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq, txd, tx_ovr, rx_ovr;
   logic        rxd = 1'b1;

   int n_chk = 0, n_fail = 0;
   logic [7:0] tx_exp[$];
   logic [7:0] rx_exp[$];

   always #4 clk = ~clk;

   midi_host_port #(.DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .addr(addr),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .irq(irq), .txd(txd), .rxd(rxd), .tx_ovr(tx_ovr), .rx_ovr(rx_ovr));

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // driver: host byte to transmit, expected serial byte queued
   task automatic host_send(logic [7:0] d, bit accepted);
      wr(BASE, d);
      if (accepted) tx_exp.push_back(d);
   endtask

   // driver: serial frame on rxd
   task automatic ser(logic [7:0] d, logic stop_bit, bit expect_byte);
      @(negedge clk); rxd = 1'b0;
      repeat (DIV) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = d[i];
         repeat (DIV) @(negedge clk);
      end
      rxd = stop_bit;
      repeat (DIV) @(negedge clk);
      rxd = 1'b1;
      if (expect_byte) rx_exp.push_back(d);
   endtask

   // read the data port and compare against the receive scoreboard
   task automatic rd_rx(string req);
      logic [7:0] v;
      logic [7:0] e;
      rd(BASE, v);
      e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'hxx;
      chk(req, v, e);
   endtask

   // monitor: decode txd frames and compare with scoreboard (R2)
   initial begin
      logic [7:0] got;
      logic [7:0] e;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (txd === 1'b0) begin
            repeat (DIV / 2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
               repeat (DIV) @(negedge clk);
               got[i] = txd;
            end
            repeat (DIV) @(negedge clk);
            chk("R2 stop bit", {7'd0, txd}, 8'h01);
            e = (tx_exp.size() > 0) ? tx_exp.pop_front() : 8'hxx;
            chk("R2 serial byte", got, e);
            repeat (DIV / 2) @(negedge clk);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v, a0, a1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 irq", {7'd0, irq}, 8'h00);
      chk("R10 txd", {7'd0, txd}, 8'h01);
      chk("R10 ovr", {6'd0, tx_ovr, rx_ovr}, 8'h00);
      rd(BASE + 1, v); chk("R10 status", v, 8'h80);
      rd(BASE, v);     chk("R10 data", v, 8'h00);

      // R1 decode: high bit set, wrong sub-slot, next block
      wr(16'h0731, 8'h15);
      wr(16'h0335, 8'h15);
      wr(16'h0339, 8'h15);
      rd(BASE + 1, v); chk("R1 no alias", v, 8'h80);
      rd(16'h0731, v); chk("R1 alias read", v, 8'h00);

      // R6 command write and acknowledge
      wr(BASE + 1, 8'hEA);
      rx_exp.push_back(8'hFE);
      chk("R8 irq set", {7'd0, irq}, 8'h01);
      rd(BASE + 1, v); chk("R6 status low bits", v, 8'h2A);
      rd_rx("R6 ack byte");
      chk("R8 irq cleared", {7'd0, irq}, 8'h00);
      rd(BASE + 1, v); chk("R5 empty flag", v, 8'hAA);
      // R9 empty read returns last value
      rd(BASE, v); chk("R9 empty read", v, 8'hFE);
      rd(BASE + 1, v); chk("R9 queue unchanged", v, 8'hAA);

      // R1 moved base
      base_addr = 10'h300;
      wr(16'h0301, 8'h05);
      rx_exp.push_back(8'hFE);
      rd(16'h0301, v); chk("R1 moved base", v, 8'h05);
      rd(16'h0300, v); chk("R1 moved base data", v, rx_exp.pop_front());
      base_addr = 10'h330;

      // R2 spaced transmit
      host_send(8'hA5, 1'b1);
      repeat (200) @(negedge clk);
      host_send(8'h01, 1'b1);
      host_send(8'h80, 1'b1);
      repeat (400) @(negedge clk);
      chk("R2 tx drained", 8'(tx_exp.size()), 8'h00);

      // R3 fill transmit queue
      for (int i = 0; i < 17; i++) host_send(8'(8'h40 + i), 1'b1);
      rd(BASE + 1, v); chk("R3 full flag", v & 8'h40, 8'h40);
      chk("R3 no ovr yet", {7'd0, tx_ovr}, 8'h00);
      host_send(8'h99, 1'b0);
      chk("R3 tx_ovr", {7'd0, tx_ovr}, 8'h01);
      repeat (18 * 10 * DIV) @(negedge clk);
      chk("R3 all kept bytes sent", 8'(tx_exp.size()), 8'h00);
      rd(BASE + 1, v); chk("R3 full cleared", v & 8'h40, 8'h00);

      // R4 receive
      ser(8'h5A, 1'b1, 1'b1);
      ser(8'h81, 1'b1, 1'b1);
      repeat (4) @(negedge clk);
      chk("R8 irq on rx", {7'd0, irq}, 8'h01);
      rd_rx("R4 rx byte 0");
      rd_rx("R4 rx byte 1");
      ser(8'h33, 1'b0, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      rd(BASE + 1, v); chk("R4 bad stop dropped", v & 8'h80, 8'h80);
      chk("R4 bad stop no irq", {7'd0, irq}, 8'h00);

      // R5 receive overflow
      for (int i = 0; i < 17; i++) ser(8'(8'h10 + i), 1'b1, i < 16);
      repeat (4) @(negedge clk);
      chk("R5 rx_ovr", {7'd0, rx_ovr}, 8'h01);
      rd(BASE + 1, v); chk("R5 data flag", v & 8'h80, 8'h00);
      for (int i = 0; i < 16; i++) rd_rx("R5 kept byte");
      rd(BASE + 1, v); chk("R5 drained", v & 8'h80, 8'h80);

      // R7 command write swept across frame completion
      for (int off = 140; off < 166; off++) begin
         fork
            ser(8'hC3, 1'b1, 1'b0);
            begin
               repeat (off) @(negedge clk);
               wr(BASE + 1, 8'h00);
            end
         join
         repeat (4) @(negedge clk);
         rd(BASE, a0);
         rd(BASE, a1);
         chk("R7 both kept", ((a0 == 8'hC3 && a1 == 8'hFE) ||
                              (a0 == 8'hFE && a1 == 8'hC3)) ? 8'h01 : 8'h00, 8'h01);
         rd(BASE + 1, v); chk("R7 nothing extra", v & 8'h80, 8'h80);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule